// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Command Generator

This block turns a tick stream into four gate commands for a full-bridge power stage. The first leg (A high side, B low side) flips state on every tick. The second leg (C and D) flips once per tick period as well, but only after a per-period delay, and that delay sets the effective duty seen by the load. The tick comes from an internal counter timebase or from an external synchronisation pulse. In internal mode, each tick is also driven out on a pin so that other converters can follow it.

Inside each tick period a ramp counter starts again from zero. The lagging leg flips in the first cycle in which the ramp reaches the phase command. That command is captured only at a tick, so the lag never changes part way through a period. Each leg has its own dead-time count. The count holds the incoming switch off for that many cycles after its partner turns off, and a count of zero makes the leg strictly complementary. When `en` is low, all four commands are held low and the internal state is cleared. The block therefore always starts from the same known state.

Top module: `psfb_pwm`

## Requirements
- R1: Out of reset, and in any cycle in which `en` is low, `gate_a`, `gate_b`, `gate_c` and `gate_d` are all low.
- R2: With `ext_mode` = 0, a tick occurs every OSC_PERIOD clock cycles and the A/B leg changes state once per tick, so `gate_a` rises every 2*OSC_PERIOD cycles.
- R3: `gate_a` and `gate_b` are never high in the same cycle, and `gate_c` and `gate_d` are never high in the same cycle.
- R4: With a dead-time count n >= 1 on a leg, that leg's rising output goes high exactly n cycles after the other output of the same leg goes low. A count of 0 means bypass: while enabled, `gate_a` is then always the inverse of `gate_b` (and likewise C/D), with no gap.
- R5: The C/D leg lags the A/B leg by L = min(cmd+1, T) cycles, where T is the tick period and cmd is the captured `phase_cmd`. At the outputs, `gate_c` rises L + `dt_cd` - `dt_ab` cycles after `gate_a` rises, and `gate_d` rises the same number of cycles after `gate_b` rises.
- R6: `phase_cmd` is captured only on a tick. A change made after a tick does not alter the lag of the period already running.
- R7: A command of 0 still gives a lag of one cycle, because the ramp restart cycle comes first.
- R8: With `ext_mode` = 1, every rising edge of `sync_in` (seen through a two-flop synchroniser) is a tick, so `gate_a` rises every two sync periods, and `sync_out` stays low.
- R9: With `ext_mode` = 0, `sync_out` pulses high for one cycle on each tick, every OSC_PERIOD cycles.
- R10: In the cycle `en` goes high, `gate_a` and `gate_c` are low and `gate_b` and `gate_d` are high. The first `gate_a` rise is seen OSC_PERIOD + `dt_ab` cycles after `en` is first sampled high.
- R11: A command of at least T-1 gives the full lag of T cycles. With both dead times at 0, `gate_c` then equals `gate_b` at every cycle (full duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds all gates low and clears state |
| ext_mode | input | 1 | 0: internal timebase, 1: ticks from `sync_in` |
| sync_in | input | 1 | External synchronisation pulse (rising edge = tick) |
| sync_out | output | 1 | One-cycle tick pulse in internal mode, low otherwise |
| phase_cmd | input | CNT_W | Ramp level at which the C/D leg flips |
| dt_ab | input | DT_W | Dead time of the A/B leg in cycles, 0 = bypass |
| dt_cd | input | DT_W | Dead time of the C/D leg in cycles, 0 = bypass |
| gate_a | output | 1 | High-side command, leading leg |
| gate_b | output | 1 | Low-side command, leading leg |
| gate_c | output | 1 | High-side command, lagging leg |
| gate_d | output | 1 | Low-side command, lagging leg |

## Verification
The bench builds the block with OSC_PERIOD = 12, CNT_W = 6 and DT_W = 3. With a 12-cycle tick period, a command of 11 or 20 reaches the saturated full-period lag within a few dozen cycles. The same six-bit command still has room above the period to show that saturation holds. Unequal dead times of 2 and 3 make the lag offset `dt_cd` - `dt_ab` nonzero, so an error that swaps the two legs changes the measured value. The external mode runs with a 14-cycle sync period, which is different from the internal period, so the bench can tell which timebase produced each measured period.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;

  // Counter value loaded when a leg changes state: the change cycle itself
  // already counts as the first blanking cycle.
  function automatic int unsigned gap_reload(int unsigned dead);
    return (dead == 0) ? 0 : dead - 1;
  endfunction

  // Lag in cycles between the leading and lagging leg for a captured command.
  function automatic int unsigned leg_lag(int unsigned cmd, int unsigned period);
    return (cmd + 1 < period) ? cmd + 1 : period;
  endfunction

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int CNT_W      = 8,
  parameter int OSC_PERIOD = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ext_sel,
  input  logic             sync_in,
  output logic [CNT_W-1:0] ramp,
  output logic             tick
);
  import psfb_pkg::*;

  localparam logic [CNT_W-1:0] RAMP_LAST = CNT_W'(OSC_PERIOD - 1);
  localparam logic [CNT_W-1:0] RAMP_TOP  = {CNT_W{1'b1}};

  tick_src_e  src;
  logic       s_meta, s_sync, s_prev;
  logic       ext_edge, int_wrap;

  assign src      = tick_src_e'(ext_sel);
  assign ext_edge = s_sync & ~s_prev;
  assign int_wrap = (ramp == RAMP_LAST);
  assign tick     = en & ((src == SRC_EXTERNAL) ? ext_edge : int_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= sync_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ramp <= '0;
    else if (!en)             ramp <= '0;
    else if (tick)            ramp <= '0;
    else if (ramp != RAMP_TOP) ramp <= ramp + 1'b1;
  end

endmodule

// File: rtl/psfb_phase.sv
module psfb_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] phase_cmd,
  output logic             leg_ab,
  output logic             leg_cd,
  output logic             trip
);
  logic [CNT_W-1:0] cmd_q;
  logic             tripped;

  // One flip of the lagging leg per period: at the ramp crossing, or forced
  // at the closing tick when the ramp never reached the command.
  assign trip = en & ~tripped & (tick | (ramp >= cmd_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_ab  <= 1'b0;
      leg_cd  <= 1'b0;
      tripped <= 1'b1;
      cmd_q   <= '0;
    end else if (!en) begin
      leg_ab  <= 1'b0;
      leg_cd  <= 1'b0;
      tripped <= 1'b1;
    end else begin
      if (trip) leg_cd <= ~leg_cd;
      if (tick) begin
        leg_ab  <= ~leg_ab;
        cmd_q   <= phase_cmd;
        tripped <= 1'b0;
      end else if (trip) begin
        tripped <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            leg,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  import psfb_pkg::*;

  logic            seen;
  logic [DT_W-1:0] gap_cnt;
  logic            settled, bypass, pass;

  assign bypass  = (dead == '0);
  assign settled = (leg == seen) && (gap_cnt == '0);
  assign pass    = bypass | settled;
  assign hi      = en & leg & pass;
  assign lo      = en & ~leg & pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      gap_cnt <= '0;
    end else if (!en) begin
      seen    <= 1'b0;
      gap_cnt <= '0;
    end else if (leg != seen) begin
      seen    <= leg;
      gap_cnt <= DT_W'(gap_reload(32'(dead)));
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm #(
  parameter int CNT_W      = 8,
  parameter int DT_W       = 4,
  parameter int OSC_PERIOD = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ext_mode,
  input  logic             sync_in,
  output logic             sync_out,
  input  logic [CNT_W-1:0] phase_cmd,
  input  logic [DT_W-1:0]  dt_ab,
  input  logic [DT_W-1:0]  dt_cd,
  output logic             gate_a,
  output logic             gate_b,
  output logic             gate_c,
  output logic             gate_d
);
  localparam int NUM_LEGS = 2;

  logic [CNT_W-1:0] ramp;
  logic             tick;
  logic             trip;
  logic             leg_ab, leg_cd;
  logic [NUM_LEGS-1:0] leg_vec, hi_vec, lo_vec;
  logic [DT_W-1:0]  dead_vec [NUM_LEGS];

  psfb_timebase #(.CNT_W(CNT_W), .OSC_PERIOD(OSC_PERIOD)) u_timebase (
    .clk(clk), .rst_n(rst_n), .en(en), .ext_sel(ext_mode),
    .sync_in(sync_in), .ramp(ramp), .tick(tick)
  );

  psfb_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ramp(ramp),
    .phase_cmd(phase_cmd), .leg_ab(leg_ab), .leg_cd(leg_cd), .trip(trip)
  );

  assign leg_vec     = {leg_cd, leg_ab};
  assign dead_vec[0] = dt_ab;
  assign dead_vec[1] = dt_cd;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_deadband #(.DT_W(DT_W)) u_band (
      .clk(clk), .rst_n(rst_n), .en(en), .leg(leg_vec[g]),
      .dead(dead_vec[g]), .hi(hi_vec[g]), .lo(lo_vec[g])
    );
  end

  assign gate_a   = hi_vec[0];
  assign gate_b   = lo_vec[0];
  assign gate_c   = hi_vec[1];
  assign gate_d   = lo_vec[1];
  assign sync_out = tick & ~ext_mode;

endmodule

// File: rtl/psfb_pwm_checker.sv
module psfb_pwm_checker #(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            ext_mode,
  input logic            sync_out,
  input logic            tick,
  input logic            leg_ab,
  input logic [DT_W-1:0] dt_ab,
  input logic            gate_a,
  input logic            gate_b,
  input logic            gate_c,
  input logic            gate_d
);

  p_ab_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a && gate_b));

  p_cd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_c && gate_d));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(gate_a || gate_b || gate_c || gate_d));

  p_leg_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (leg_ab != $past(leg_ab))) |-> $past(tick));

  p_sync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> !sync_out);

  p_bypass_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dt_ab == '0) |-> (gate_a != gate_b));

  p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_a) && dt_ab > DT_W'(1) && $stable(dt_ab)) |=> (!gate_b || dt_ab == '0));

endmodule

bind psfb_pwm psfb_pwm_checker #(.DT_W(DT_W)) i_psfb_pwm_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .ext_mode(ext_mode), .sync_out(sync_out),
  .tick(tick), .leg_ab(leg_ab), .dt_ab(dt_ab), .gate_a(gate_a), .gate_b(gate_b),
  .gate_c(gate_c), .gate_d(gate_d)
);

// File: tb/test_psfb_pwm.sv
module test_psfb_pwm;
  localparam int P  = 12;
  localparam int CW = 6;
  localparam int DW = 3;
  localparam int Q  = 14;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ext_mode = 1'b0, sync_in = 1'b0;
  logic [CW-1:0] phase_cmd = CW'(4);
  logic [DW-1:0] dt_ab = DW'(2), dt_cd = DW'(3);
  logic sync_out, gate_a, gate_b, gate_c, gate_d;
  bit   sync_run = 0;

  int n_checks = 0, n_errors = 0, cyc = 0, overlaps = 0;
  int exp_q[$];
  string tag_q[$];
  bit armed = 0;
  int t_start = 0;
  logic pa_prev = 0, pc_prev = 0;

  psfb_pwm #(.CNT_W(CW), .DT_W(DW), .OSC_PERIOD(P)) i_psfb_pwm (
    .clk(clk), .rst_n(rst_n), .en(en), .ext_mode(ext_mode), .sync_in(sync_in),
    .sync_out(sync_out), .phase_cmd(phase_cmd), .dt_ab(dt_ab), .dt_cd(dt_cd),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c), .gate_d(gate_d)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int lag_of(int cmd, int period);
    if (cmd >= period - 1) return period;
    return cmd + 1;
  endfunction

  function automatic logic pin(int i);
    case (i)
      0: return gate_a;
      1: return gate_b;
      2: return gate_c;
      3: return gate_d;
      default: return sync_out;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(int i, bit rising);
    logic p;
    p = pin(i);
    forever begin
      @(negedge clk);
      if (pin(i) == rising && p != rising) break;
      p = pin(i);
    end
  endtask

  task automatic count_until_rise(int j, output int n);
    logic p;
    p = pin(j);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (pin(j) && !p) break;
      p = pin(j);
    end
  endtask

  // Driver side of the scoreboard: expected lag from gate_a rise to gate_c rise
  task automatic expect_lag(int cmd, int period, string tag);
    phase_cmd = CW'(cmd);
    repeat (6 * period) @(negedge clk);
    exp_q.push_back(lag_of(cmd, period) + int'(dt_cd) - int'(dt_ab));
    tag_q.push_back(tag);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor side: pairs each gate_a rise with the following gate_c rise
  always @(negedge clk) begin
    if ((gate_a && gate_b) || (gate_c && gate_d)) overlaps++;
    if (gate_a && !pa_prev && !armed && exp_q.size() > 0) begin
      armed   = 1;
      t_start = cyc;
    end else if (gate_c && !pc_prev && armed) begin
      int e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      chk((cyc - t_start) == e, tg, cyc - t_start, e);
      armed = 0;
    end
    pa_prev = gate_a;
    pc_prev = gate_c;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (sync_run) begin
        sync_in = 1'b1;
        repeat (2) @(negedge clk);
        sync_in = 1'b0;
        repeat (Q - 3) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int n, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({gate_a, gate_b, gate_c, gate_d} == 4'b0000, "R1 reset outputs",
        {gate_a, gate_b, gate_c, gate_d}, 0);

    // R10 restart state and first rise
    en = 1'b1;
    #1;
    chk({gate_a, gate_b, gate_c, gate_d} == 4'b0101, "R10 restart state",
        {gate_a, gate_b, gate_c, gate_d}, 5);
    count_until_rise(0, n);
    chk(n == P + 2, "R10 first A rise", n, P + 2);

    // R9 sync_out period in internal mode
    wait_edge(4, 1);
    count_until_rise(4, n);
    chk(n == P, "R9 sync_out period", n, P);

    // R2 A period
    wait_edge(0, 1);
    count_until_rise(0, n);
    chk(n == 2 * P, "R2 A period", n, 2 * P);

    // R4 dead time on each leg
    wait_edge(0, 0);
    count_until_rise(1, n);
    chk(n == 2, "R4 A fall to B rise", n, 2);
    wait_edge(2, 0);
    count_until_rise(3, n);
    chk(n == 3, "R4 C fall to D rise", n, 3);

    // R5 lag for several commands, R7 minimum, R11 saturation
    expect_lag(4, P, "R5 lag cmd 4");
    wait_edge(1, 1);
    count_until_rise(3, n);
    chk(n == 6, "R5 B rise to D rise", n, 6);
    expect_lag(7, P, "R5 lag cmd 7");
    expect_lag(0, P, "R7 lag cmd 0");
    expect_lag(11, P, "R11 lag cmd 11");
    expect_lag(20, P, "R11 lag cmd 20");

    // R6 command captured only at a tick
    phase_cmd = CW'(8);
    repeat (6 * P) @(negedge clk);
    wait_edge(0, 1);
    phase_cmd = CW'(2);
    count_until_rise(2, n);
    chk(n == 10, "R6 mid-period change ignored", n, 10);
    expect_lag(2, P, "R6 new command next period");

    // R4 bypass: complementary with no gap
    dt_ab = '0;
    dt_cd = '0;
    repeat (4 * P) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if (gate_a == gate_b || gate_c == gate_d) bad++;
    end
    chk(bad == 0, "R4 bypass complementary", bad, 0);
    expect_lag(5, P, "R5 lag cmd 5 bypass");

    // R11 full duty: C equals B
    phase_cmd = CW'(20);
    repeat (6 * P) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if (gate_c != gate_b) bad++;
    end
    chk(bad == 0, "R11 C follows B", bad, 0);

    // R1 disable mid-run
    en = 1'b0;
    #1;
    chk({gate_a, gate_b, gate_c, gate_d} == 4'b0000, "R1 disabled outputs",
        {gate_a, gate_b, gate_c, gate_d}, 0);
    repeat (3) @(negedge clk);
    chk({gate_a, gate_b, gate_c, gate_d} == 4'b0000, "R1 stay low",
        {gate_a, gate_b, gate_c, gate_d}, 0);

    // R8 external synchronisation
    dt_ab = DW'(2);
    dt_cd = DW'(3);
    ext_mode = 1'b1;
    sync_run = 1;
    @(negedge clk);
    en = 1'b1;
    repeat (4 * Q) @(negedge clk);
    wait_edge(0, 1);
    count_until_rise(0, n);
    chk(n == 2 * Q, "R8 A period from sync", n, 2 * Q);
    bad = 0;
    for (int k = 0; k < 3 * Q; k++) begin
      @(negedge clk);
      if (sync_out) bad++;
    end
    chk(bad == 0, "R8 sync_out quiet", bad, 0);
    expect_lag(3, Q, "R8 R5 lag external cmd 3");

    chk(overlaps == 0, "R3 no overlap", overlaps, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule